// File: doc/BRIEF.md
# Strided Burst Mover with Circular Bit Rotation

This block copies a burst of 64-bit words between a word-wide memory port and one of two on-chip 64-word buffers, in either direction. Each side has its own start address and address stride, so a burst can gather from or scatter to regularly spaced locations. While the words move, the whole burst is handled as one circular bit string and rotated by a programmed bit count. This turns a plane shift inside a wrapped region into a side effect of the copy.

A single-cycle start pulse latches every parameter. The parameter inputs can then be rewritten for the next burst while the current one is still running. A third destination, the configuration sink, can take the words in place of a buffer. A refresh flag asks for one refresh pulse at a fixed point, which is when the burst completes. This keeps several movers in step with each other.

The memory returns read data in request order, flagged by a valid signal, after any latency. The buffers give read data one cycle after a read enable.

Top module: `burst_rotate_mover`

## Requirements
- R1: All parameter inputs are latched on an accepted start. Changing them while busy has no effect on the running burst.
- R2: A start pulse while `busy` is high is ignored: no second burst, no extra writes, no extra done pulse.
- R3: Word k of a burst of L words holds global bits 64k..64k+63. Destination bit j equals source bit (j − r) mod 64L, where r is `rotAmt` taken modulo 64L, so a positive amount moves bits toward higher indices.
- R4: Source and destination word i sit at base + i×stride on their own side. Memory addresses wrap at the memory address width and buffer addresses wrap at 64. Destination words are written in increasing i.
- R5: `toMemDir`=0 copies memory to buffer and `toMemDir`=1 copies buffer to memory. `bufSel` follows the latched buffer select and stays stable for the whole burst.
- R6: With `cfgDest`=1 and `toMemDir`=0, each word raises `cfgLoad` with its data on `bufWrData`, and `bufWrEn` stays low. With `toMemDir`=1, `cfgDest` has no effect.
- R7: `busy` is high from the cycle after an accepted start of L>0 words up to the cycle before `done`. `done` is a one-cycle pulse in the cycle that presents the last of exactly L destination writes, and `busy` is low in that cycle.
- R8: A burst of length zero raises `done` in the cycle after the start, never raises `busy`, and makes no access.
- R9: `refreshPulse` is high exactly in the `done` cycle of a burst started with `refreshAfter`=1, and never otherwise.
- R10: While `busy` and `done` are both low, no memory request, buffer read, buffer write or config strobe is driven.
- R11: Memory read data is taken whenever `memRvalid` is high, in request order, for any latency of one cycle or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted when idle |
| xferLen | input | 7 | Burst length in words (0..64) |
| rotAmt | input | 12 | Rotation amount in bits |
| memBase | input | MEM_AW | Memory start address |
| memStride | input | MEM_AW | Memory address stride |
| bufBase | input | 6 | Buffer start address |
| bufStride | input | 6 | Buffer address stride |
| toMemDir | input | 1 | 0: memory to buffer, 1: buffer to memory |
| bufSelIn | input | 1 | Buffer 0 or 1 |
| cfgDest | input | 1 | Send words to the configuration sink |
| refreshAfter | input | 1 | Request a refresh pulse at completion |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle completion pulse |
| refreshPulse | output | 1 | Scheduled refresh strobe |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | MEM_AW | Memory word address |
| memWdata | output | 64 | Memory write data |
| memRvalid | input | 1 | Memory read data valid |
| memRdata | input | 64 | Memory read data |
| bufSel | output | 1 | Selected buffer |
| bufRdEn | output | 1 | Buffer read enable |
| bufRdAddr | output | 6 | Buffer read address |
| bufRdData | input | 64 | Buffer read data, one cycle after enable |
| bufWrEn | output | 1 | Buffer write enable |
| bufWrAddr | output | 6 | Buffer write address |
| bufWrData | output | 64 | Buffer or config write data |
| cfgLoad | output | 1 | Config sink word strobe |

## Verification
The bench builds the block with an 8-bit memory address, a 64-bit word and a 64-word buffer. Memory strides can therefore wrap around a 256-word space, and buffer strides can revisit addresses within a single burst. Rotation amounts span the full 0..4095 range, including amounts larger than the burst. Its memory model answers reads three cycles late, which keeps several responses in flight while the rotation window is being filled.

// File: rtl/brm_pkg.sv
package brm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FLUSH
  } brm_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeLead;  // first source word: seed the window
    logic push;      // later source word: emit one rotated word
    logic flush;     // close the circle with the held leading word
    logic fromBuf;   // source is the buffer, destination is memory
    logic toCfg;     // destination is the config sink
  } brm_strobe_t;

endpackage

// File: rtl/brm_ctrl.sv
module brm_ctrl
  import brm_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int BUF_DEPTH = 64,
  parameter int MEM_AW    = 10,
  localparam int SH_W     = $clog2(DATA_W),
  localparam int BUF_AW   = $clog2(BUF_DEPTH),
  localparam int LEN_W    = BUF_AW + 1,
  localparam int ROT_W    = $clog2(BUF_DEPTH * DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LEN_W-1:0]  xferLen,
  input  logic [ROT_W-1:0]  rotAmt,
  input  logic [MEM_AW-1:0] memBase,
  input  logic [MEM_AW-1:0] memStride,
  input  logic [BUF_AW-1:0] bufBase,
  input  logic [BUF_AW-1:0] bufStride,
  input  logic              toMemDir,
  input  logic              bufSelIn,
  input  logic              cfgDest,
  input  logic              refreshAfter,
  input  logic              memRvalid,
  output logic              busy,
  output logic              done,
  output logic              refreshPulse,
  output logic              bufSel,
  output logic              memRdReq,
  output logic              bufRdEn,
  output logic [MEM_AW-1:0] issueAddr,
  output brm_strobe_t       strb,
  output logic [MEM_AW-1:0] dstAddr,
  output logic [SH_W-1:0]   shiftAmt
);

  brm_state_e        state;
  logic [LEN_W-1:0]  lenR;
  logic              fromBufR;
  logic              cfgR;
  logic              refR;
  logic [MEM_AW-1:0] srcBaseR;
  logic [MEM_AW-1:0] srcStrideR;
  logic [MEM_AW-1:0] dstStrideR;
  logic [LEN_W-1:0]  issueIdx;
  logic [LEN_W-1:0]  issueLeft;
  logic [LEN_W-1:0]  respCnt;
  logic              bufPend;

  // capture-time arithmetic
  logic [LEN_W-1:0]  rotWordsIn;
  logic [LEN_W-1:0]  qMod;
  logic [LEN_W-1:0]  firstIdx;
  logic [MEM_AW-1:0] srcBaseIn;
  logic [MEM_AW-1:0] srcStrideIn;
  logic [MEM_AW-1:0] dstBaseIn;
  logic [MEM_AW-1:0] dstStrideIn;
  logic [MEM_AW-1:0] firstAddr;

  always_comb begin
    rotWordsIn  = {1'b0, rotAmt[ROT_W-1:SH_W]};
    qMod        = (xferLen == '0) ? '0 : (rotWordsIn % xferLen);
    firstIdx    = xferLen - qMod - LEN_W'(1);
    srcBaseIn   = toMemDir ? MEM_AW'(bufBase)   : memBase;
    srcStrideIn = toMemDir ? MEM_AW'(bufStride) : memStride;
    dstBaseIn   = toMemDir ? memBase   : MEM_AW'(bufBase);
    dstStrideIn = toMemDir ? memStride : MEM_AW'(bufStride);
    firstAddr   = srcBaseIn + MEM_AW'(MEM_AW'(firstIdx) * srcStrideIn);
  end

  logic issueNow;
  logic srcValid;
  logic lastResp;

  assign issueNow = (state == ST_RUN) && (issueLeft != '0);
  assign srcValid = (state == ST_RUN) && (fromBufR ? bufPend : memRvalid);
  assign lastResp = (respCnt == lenR - LEN_W'(1));

  assign busy     = (state != ST_IDLE);
  assign memRdReq = issueNow && !fromBufR;
  assign bufRdEn  = issueNow && fromBufR;

  always_comb begin
    strb          = '0;
    strb.takeLead = srcValid && (respCnt == '0);
    strb.push     = srcValid && (respCnt != '0);
    strb.flush    = (state == ST_FLUSH);
    strb.fromBuf  = fromBufR;
    strb.toCfg    = cfgR && !fromBufR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      lenR         <= '0;
      fromBufR     <= 1'b0;
      cfgR         <= 1'b0;
      refR         <= 1'b0;
      bufSel       <= 1'b0;
      shiftAmt     <= '0;
      srcBaseR     <= '0;
      srcStrideR   <= '0;
      dstStrideR   <= '0;
      issueIdx     <= '0;
      issueLeft    <= '0;
      issueAddr    <= '0;
      respCnt      <= '0;
      dstAddr      <= '0;
      bufPend      <= 1'b0;
      done         <= 1'b0;
      refreshPulse <= 1'b0;
    end else begin
      done         <= 1'b0;
      refreshPulse <= 1'b0;
      bufPend      <= issueNow && fromBufR;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            lenR       <= xferLen;
            fromBufR   <= toMemDir;
            cfgR       <= cfgDest;
            refR       <= refreshAfter;
            bufSel     <= bufSelIn;
            shiftAmt   <= rotAmt[SH_W-1:0];
            srcBaseR   <= srcBaseIn;
            srcStrideR <= srcStrideIn;
            dstStrideR <= dstStrideIn;
            dstAddr    <= dstBaseIn;
            issueIdx   <= firstIdx;
            issueAddr  <= firstAddr;
            issueLeft  <= xferLen;
            respCnt    <= '0;
            if (xferLen == '0) begin
              done         <= 1'b1;
              refreshPulse <= refreshAfter;
            end else begin
              state <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (issueNow) begin
            issueLeft <= issueLeft - LEN_W'(1);
            if (issueIdx == lenR - LEN_W'(1)) begin
              issueIdx  <= '0;
              issueAddr <= srcBaseR;
            end else begin
              issueIdx  <= issueIdx + LEN_W'(1);
              issueAddr <= issueAddr + srcStrideR;
            end
          end
          if (srcValid) begin
            respCnt <= respCnt + LEN_W'(1);
            if (respCnt != '0) dstAddr <= dstAddr + dstStrideR;
            if (lastResp) state <= ST_FLUSH;
          end
        end
        ST_FLUSH: begin
          state        <= ST_IDLE;
          done         <= 1'b1;
          refreshPulse <= refR;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/brm_datapath.sv
module brm_datapath
  import brm_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int MEM_AW = 10,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  brm_strobe_t       strb,
  input  logic [SH_W-1:0]   shiftAmt,
  input  logic [MEM_AW-1:0] dstAddr,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] bufRdData,
  output logic              wrValid,
  output logic              wrToMem,
  output logic              wrCfg,
  output logic [MEM_AW-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);

  logic [DATA_W-1:0]   inWord;
  logic [DATA_W-1:0]   leadR;
  logic [DATA_W-1:0]   prevR;
  logic [DATA_W-1:0]   upper;
  logic [2*DATA_W-1:0] window;
  logic [2*DATA_W-1:0] shifted;
  logic [SH_W:0]       rightBy;
  logic [DATA_W-1:0]   rotWord;

  assign inWord = strb.fromBuf ? bufRdData : memRdata;

  // funnel: newer word above the held one, take DATA_W bits starting at DATA_W - s
  assign upper   = strb.flush ? leadR : inWord;
  assign window  = {upper, prevR};
  assign rightBy = (SH_W+1)'(DATA_W) - {1'b0, shiftAmt};
  assign shifted = window >> rightBy;
  assign rotWord = shifted[DATA_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leadR   <= '0;
      prevR   <= '0;
      wrValid <= 1'b0;
      wrToMem <= 1'b0;
      wrCfg   <= 1'b0;
      wrAddr  <= '0;
      wrData  <= '0;
    end else begin
      wrValid <= strb.push || strb.flush;
      wrToMem <= strb.fromBuf;
      wrCfg   <= strb.toCfg;
      if (strb.takeLead) begin
        leadR <= inWord;
        prevR <= inWord;
      end
      if (strb.push) prevR <= inWord;
      if (strb.push || strb.flush) begin
        wrData <= rotWord;
        wrAddr <= dstAddr;
      end
    end
  end

endmodule

// File: rtl/burst_rotate_mover.sv
module burst_rotate_mover
  import brm_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int BUF_DEPTH = 64,
  parameter int MEM_AW    = 10,
  localparam int BUF_AW   = $clog2(BUF_DEPTH),
  localparam int LEN_W    = BUF_AW + 1,
  localparam int SH_W     = $clog2(DATA_W),
  localparam int ROT_W    = $clog2(BUF_DEPTH * DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LEN_W-1:0]  xferLen,
  input  logic [ROT_W-1:0]  rotAmt,
  input  logic [MEM_AW-1:0] memBase,
  input  logic [MEM_AW-1:0] memStride,
  input  logic [BUF_AW-1:0] bufBase,
  input  logic [BUF_AW-1:0] bufStride,
  input  logic              toMemDir,
  input  logic              bufSelIn,
  input  logic              cfgDest,
  input  logic              refreshAfter,
  output logic              busy,
  output logic              done,
  output logic              refreshPulse,
  output logic              memReq,
  output logic              memWe,
  output logic [MEM_AW-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memRvalid,
  input  logic [DATA_W-1:0] memRdata,
  output logic              bufSel,
  output logic              bufRdEn,
  output logic [BUF_AW-1:0] bufRdAddr,
  input  logic [DATA_W-1:0] bufRdData,
  output logic              bufWrEn,
  output logic [BUF_AW-1:0] bufWrAddr,
  output logic [DATA_W-1:0] bufWrData,
  output logic              cfgLoad
);

  brm_strobe_t       strb;
  logic              memRdReq;
  logic [MEM_AW-1:0] issueAddr;
  logic [MEM_AW-1:0] dstAddr;
  logic [SH_W-1:0]   shiftAmt;
  logic              wrValid;
  logic              wrToMem;
  logic              wrCfg;
  logic [MEM_AW-1:0] wrAddr;
  logic [DATA_W-1:0] wrData;

  brm_ctrl #(
    .DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH), .MEM_AW(MEM_AW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .xferLen(xferLen), .rotAmt(rotAmt),
    .memBase(memBase), .memStride(memStride), .bufBase(bufBase), .bufStride(bufStride),
    .toMemDir(toMemDir), .bufSelIn(bufSelIn), .cfgDest(cfgDest),
    .refreshAfter(refreshAfter), .memRvalid(memRvalid),
    .busy(busy), .done(done), .refreshPulse(refreshPulse), .bufSel(bufSel),
    .memRdReq(memRdReq), .bufRdEn(bufRdEn), .issueAddr(issueAddr),
    .strb(strb), .dstAddr(dstAddr), .shiftAmt(shiftAmt)
  );

  brm_datapath #(
    .DATA_W(DATA_W), .MEM_AW(MEM_AW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .shiftAmt(shiftAmt), .dstAddr(dstAddr),
    .memRdata(memRdata), .bufRdData(bufRdData),
    .wrValid(wrValid), .wrToMem(wrToMem), .wrCfg(wrCfg),
    .wrAddr(wrAddr), .wrData(wrData)
  );

  assign memWe     = wrValid && wrToMem;
  assign memReq    = memRdReq || memWe;
  assign memAddr   = memWe ? wrAddr : issueAddr;
  assign memWdata  = wrData;
  assign bufRdAddr = issueAddr[BUF_AW-1:0];
  assign bufWrAddr = wrAddr[BUF_AW-1:0];
  assign bufWrData = wrData;
  assign bufWrEn   = wrValid && !wrToMem && !wrCfg;
  assign cfgLoad   = wrValid && !wrToMem && wrCfg;

endmodule

// File: rtl/brm_checker.sv
module brm_checker #(
  parameter int LEN_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [LEN_W-1:0] xferLen,
  input logic             busy,
  input logic             done,
  input logic             refreshPulse,
  input logic             memReq,
  input logic             memWe,
  input logic             bufRdEn,
  input logic             bufWrEn,
  input logic             cfgLoad,
  input logic             bufSel
);

  logic [LEN_W:0]   wrCnt;
  logic [LEN_W-1:0] lenCap;
  logic             curWrite;

  assign curWrite = (memReq && memWe) || bufWrEn || cfgLoad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrCnt  <= '0;
      lenCap <= '0;
    end else if (start && !busy) begin
      wrCnt  <= '0;
      lenCap <= xferLen;
    end else if (curWrite) begin
      wrCnt <= wrCnt + 1'b1;
    end
  end

  // R7: exactly the latched number of writes by the done cycle
  a_r7_write_count: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ((wrCnt + {{LEN_W{1'b0}}, curWrite}) == {1'b0, lenCap}));

  // R7: busy only drops together with done
  a_r7_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R8: zero-length start completes immediately without busy
  a_r8_zero_length: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && xferLen == '0) |=> (done && !busy));

  // R10: no traffic outside a burst
  a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !done) |-> !(memReq || bufRdEn || bufWrEn || cfgLoad));

  // R6: config strobe and buffer write never together
  a_r6_cfg_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgLoad && bufWrEn));

  // R5: buffer select held during a burst
  a_r5_sel_stable: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(bufSel));

  // R9: refresh only at completion
  a_r9_refresh_at_done: assert property (@(posedge clk) disable iff (!rstN)
    refreshPulse |-> done);

endmodule

bind burst_rotate_mover brm_checker #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .xferLen(xferLen), .busy(busy),
  .done(done), .refreshPulse(refreshPulse), .memReq(memReq), .memWe(memWe),
  .bufRdEn(bufRdEn), .bufWrEn(bufWrEn), .cfgLoad(cfgLoad), .bufSel(bufSel)
);

// File: tb/burst_rotate_mover_tb.sv
`timescale 1ns/1ps
module burst_rotate_mover_tb;

  localparam int DW = 64;
  localparam int DEPTH = 64;
  localparam int MAW = 8;
  localparam int MWORDS = 1 << MAW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [6:0] xferLen = '0;
  logic [11:0] rotAmt = '0;
  logic [MAW-1:0] memBase = '0, memStride = '0;
  logic [5:0] bufBase = '0, bufStride = '0;
  logic toMemDir = 1'b0, bufSelIn = 1'b0, cfgDest = 1'b0, refreshAfter = 1'b0;
  logic busy, done, refreshPulse, memReq, memWe, memRvalid;
  logic [MAW-1:0] memAddr;
  logic [DW-1:0] memWdata, memRdata, bufRdData, bufWrData;
  logic bufSel, bufRdEn, bufWrEn, cfgLoad;
  logic [5:0] bufRdAddr, bufWrAddr;

  always #4 clk = ~clk;

  burst_rotate_mover #(.DATA_W(DW), .BUF_DEPTH(DEPTH), .MEM_AW(MAW)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .xferLen(xferLen), .rotAmt(rotAmt),
    .memBase(memBase), .memStride(memStride), .bufBase(bufBase), .bufStride(bufStride),
    .toMemDir(toMemDir), .bufSelIn(bufSelIn), .cfgDest(cfgDest), .refreshAfter(refreshAfter),
    .busy(busy), .done(done), .refreshPulse(refreshPulse), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRvalid(memRvalid), .memRdata(memRdata),
    .bufSel(bufSel), .bufRdEn(bufRdEn), .bufRdAddr(bufRdAddr), .bufRdData(bufRdData),
    .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr), .bufWrData(bufWrData), .cfgLoad(cfgLoad)
  );

  // memory model, three-cycle read latency, in order
  logic [DW-1:0] memArr [MWORDS];
  logic [DW-1:0] bufArr [2][DEPTH];
  logic [DW-1:0] cfgLog [DEPTH];
  int cfgCnt = 0;
  logic rv0 = 1'b0, rv1 = 1'b0, rv2 = 1'b0;
  logic [DW-1:0] rd0 = '0, rd1 = '0, rd2 = '0;
  assign memRvalid = rv2;
  assign memRdata  = rd2;

  always @(posedge clk) begin
    rv0 <= memReq && !memWe;
    rd0 <= memArr[memAddr];
    rv1 <= rv0; rd1 <= rd0;
    rv2 <= rv1; rd2 <= rd1;
    if (memReq && memWe) memArr[memAddr] <= memWdata;
    if (bufRdEn) bufRdData <= bufArr[bufSel][bufRdAddr];
    if (bufWrEn) bufArr[bufSel][bufWrAddr] <= bufWrData;
    if (cfgLoad) begin
      cfgLog[cfgCnt % DEPTH] <= bufWrData;
      cfgCnt <= cfgCnt + 1;
    end
  end

  int tests = 0;
  int fails = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [DW-1:0] srcW [DEPTH];
  logic [DW-1:0] outW [DEPTH];
  logic [DW-1:0] expMem [MWORDS];
  logic [DW-1:0] expBuf [2][DEPTH];

  // bench model of the circular rotation (R3)
  task automatic computeRot(input int len, input int rot);
    int total = len * DW;
    int r = rot % total;
    for (int j = 0; j < total; j++) begin
      int s = (j - r + total) % total;
      outW[j / DW][j % DW] = srcW[s / DW][s % DW];
    end
  endtask

  task automatic runXfer(input bit dir, input bit cfg, input bit sel, input bit refr,
                         input int len, input int rot, input int mB, input int mS,
                         input int bB, input int bS, input bit disturb, input string tag);
    int wr = 0;
    int acc = 0;
    int cyc = 0;
    int bad = -1;
    logic [63:0] badAct = '0, badExp = '0;
    for (int i = 0; i < len; i++)
      srcW[i] = dir ? bufArr[sel][(bB + i * bS) & 63] : memArr[(mB + i * mS) & (MWORDS - 1)];
    if (len > 0) computeRot(len, rot);
    for (int a = 0; a < MWORDS; a++) expMem[a] = memArr[a];
    for (int a = 0; a < DEPTH; a++) begin expBuf[0][a] = bufArr[0][a]; expBuf[1][a] = bufArr[1][a]; end
    for (int k = 0; k < len; k++) begin
      if (dir) expMem[(mB + k * mS) & (MWORDS - 1)] = outW[k];
      else if (!cfg) expBuf[sel][(bB + k * bS) & 63] = outW[k];
    end
    cfgCnt = 0;
    toMemDir = dir; cfgDest = cfg; bufSelIn = sel; refreshAfter = refr;
    xferLen = 7'(len); rotAmt = 12'(rot);
    memBase = MAW'(mB); memStride = MAW'(mS); bufBase = 6'(bB); bufStride = 6'(bS);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (len == 0) check(done && !busy, {tag, " R8 zero length done"}, {busy, done}, 2'b01);
    else check(busy && !done, {tag, " R7 busy after start"}, {busy, done}, 2'b10);
    while (!done && cyc < 3000) begin
      if (memReq || bufRdEn || bufWrEn || cfgLoad) acc++;
      if ((memReq && memWe) || bufWrEn || cfgLoad) wr++;
      if (disturb && cyc == 1) begin
        // R1/R2: rewrite parameters and pulse start mid-burst
        start = 1'b1;
        toMemDir = ~dir; cfgDest = ~cfg; bufSelIn = ~sel; refreshAfter = ~refr;
        xferLen = 7'($urandom_range(1, 64)); rotAmt = 12'($urandom);
        memBase = MAW'($urandom); memStride = MAW'($urandom);
        bufBase = 6'($urandom); bufStride = 6'($urandom);
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(done, {tag, " R7 done seen"}, done, 1);
    if ((memReq && memWe) || bufWrEn || cfgLoad) wr++;
    if (memReq || bufRdEn || bufWrEn || cfgLoad) acc++;
    check(!busy, {tag, " R7 busy low at done"}, busy, 0);
    check(wr == len, {tag, " R7 write count"}, wr, len);
    check(refreshPulse == refr, {tag, " R9 refresh at done"}, refreshPulse, refr);
    if (len == 0) check(acc == 0, {tag, " R8 no access"}, acc, 0);
    @(negedge clk);
    check(!done && !refreshPulse, {tag, " R7 R9 single pulse"}, {done, refreshPulse}, 0);
    check(!(memReq || bufRdEn || bufWrEn || cfgLoad), {tag, " R10 quiet after"},
          {memReq, bufRdEn, bufWrEn, cfgLoad}, 0);
    @(negedge clk);
    check(!busy && !done, {tag, " R2 no restart"}, {busy, done}, 0);
    for (int a = 0; a < MWORDS; a++)
      if (bad < 0 && memArr[a] !== expMem[a]) begin bad = a; badAct = memArr[a]; badExp = expMem[a]; end
    for (int a = 0; a < DEPTH; a++) begin
      if (bad < 0 && bufArr[0][a] !== expBuf[0][a]) begin bad = 1000 + a; badAct = bufArr[0][a]; badExp = expBuf[0][a]; end
      if (bad < 0 && bufArr[1][a] !== expBuf[1][a]) begin bad = 2000 + a; badAct = bufArr[1][a]; badExp = expBuf[1][a]; end
    end
    check(bad < 0, {tag, " R3 R4 R5 R11 destination image"}, badAct, badExp);
    if (cfg && !dir) begin
      check(cfgCnt == len, {tag, " R6 config strobes"}, cfgCnt, len);
      bad = -1;
      for (int k = 0; k < len; k++)
        if (bad < 0 && cfgLog[k] !== outW[k]) begin bad = k; badAct = cfgLog[k]; badExp = outW[k]; end
      check(bad < 0, {tag, " R6 R3 config data"}, badAct, badExp);
    end else begin
      check(cfgCnt == 0, {tag, " R6 no config strobes"}, cfgCnt, 0);
    end
  endtask

  initial begin
    #(8 * 190000);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seedTmp;
    seedTmp = $urandom(32'd5150);
    for (int a = 0; a < MWORDS; a++) memArr[a] = {$urandom, $urandom};
    for (int a = 0; a < DEPTH; a++) begin
      bufArr[0][a] = {$urandom, $urandom};
      bufArr[1][a] = {$urandom, $urandom};
      cfgLog[a] = '0;
    end
    repeat (3) @(negedge clk);
    check(!busy && !done && !memReq && !bufWrEn && !cfgLoad && !refreshPulse, "R10 reset state",
          {busy, done, memReq, bufWrEn, cfgLoad, refreshPulse}, 0);
    rstN = 1'b1;
    @(negedge clk);

    runXfer(0, 0, 0, 0, 8, 0, 10, 1, 0, 1, 0, "plain copy R4");
    runXfer(0, 0, 1, 0, 1, 37, 5, 1, 9, 1, 0, "single word rotate R3");
    runXfer(0, 0, 0, 1, 64, 4095, 0, 1, 0, 1, 0, "max burst max rotate R3");
    runXfer(0, 0, 1, 0, 3, 200, 40, 2, 3, 5, 0, "rotate beyond total R3");
    runXfer(0, 0, 0, 1, 0, 77, 0, 1, 0, 1, 0, "zero length R8");
    runXfer(0, 1, 0, 0, 5, 130, 20, 3, 0, 1, 0, "config sink R6");
    runXfer(1, 1, 1, 0, 6, 65, 100, 4, 7, 3, 0, "config ignored buf to mem R6");
    runXfer(1, 0, 1, 1, 20, 1000, 250, 7, 60, 3, 0, "wrapping strides R4 R5");
    runXfer(0, 0, 0, 0, 16, 300, 30, 1, 12, 1, 1, "param rewrite R1 R2");
    runXfer(1, 0, 0, 0, 12, 77, 0, 0, 2, 1, 1, "stride zero R1 R4");

    for (int n = 0; n < 30; n++) begin
      int len = (n % 7 == 6) ? 0 : $urandom_range(1, 64);
      runXfer(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), len,
              $urandom_range(0, 4095), $urandom_range(0, 255), $urandom_range(0, 255),
              $urandom_range(0, 63), $urandom_range(0, 63), (len >= 8) ? 1'($urandom) : 1'b0,
              "random R1 R3 R4 R11");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule